// File: doc/BRIEF.md
# Windowed Loop Lock Detector

This block judges whether a tracking loop has settled. Each time the indicator strobe is high, it adds an unsigned per-symbol quality value to a running sum. When the sum covers a full window of symbols, it compares the total with a fraction of the total that an ideal signal would give. The ideal total is the static per-symbol ideal value shifted left by log2 of the window length. The block then updates a lock flag, which downstream loop filters use to switch to their narrower post-lock gains.

The window length has two options, 2^WIN_SHORT_LOG2 or 2^WIN_LONG_LOG2 symbols, with defaults of 16384 and 32768. The threshold fraction also has two options, one half or three quarters. The three-quarter value is built from two shifted copies of the ideal sum, so no multiplier is needed. A two-state machine holds the verdict. State ACQUIRE moves to LOCKED when a window total meets the threshold (transition T_LOCK). State LOCKED returns to ACQUIRE when a window total falls short (transition T_DROP). A synchronous restart forces ACQUIRE from either state (transition T_RESTART), empties the sum and starts a new window. A one-cycle pulse marks the end of each window.

Top module: `lld_lock_detect`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, lock_flag and win_done are both 0 and the machine is in ACQUIRE.
- R2: win_done rises for exactly one clock cycle. It rises in the cycle after the clock edge that accepts the N-th strobed symbol of a window. N is 2^WIN_SHORT_LOG2 when win_sel is 0 and 2^WIN_LONG_LOG2 when win_sel is 1.
- R3: Cycles with ind_valid low are ignored: they neither advance the window count nor add to the sum.
- R4: With thr_sel = 0 the threshold is ideal_value * N / 2.
- R5: With thr_sel = 1 the threshold is ideal_value * N * 3 / 4.
- R6: T_LOCK: in ACQUIRE, a window whose total is greater than or equal to the threshold sets lock_flag to 1. A total exactly equal to the threshold counts as a pass.
- R7: T_DROP: in LOCKED, a window whose total is below the threshold clears lock_flag to 0. A passing window keeps it at 1. In ACQUIRE, a failing window keeps it at 0.
- R8: lock_flag changes only in the cycle in which win_done is 1, or in the cycle after a restart.
- R9: T_RESTART: a restart cycle clears lock_flag and win_done at the next edge, empties the sum and restarts the window count. Restart takes priority over a strobed symbol in the same cycle, and that symbol is discarded.
- R10: The sum never wraps. A window whose symbols are all 255 passes either threshold for any ideal_value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| restart | input | 1 | Synchronous restart, active high |
| win_sel | input | 1 | Window length select: 0 short, 1 long (static) |
| thr_sel | input | 1 | Threshold fraction select: 0 one half, 1 three quarters (static) |
| ideal_value | input | IND_W | Per-symbol indicator value of an ideal signal (static) |
| ind_valid | input | 1 | Strobe: ind_value holds a symbol's indicator |
| ind_value | input | IND_W | Unsigned per-symbol lock indicator |
| lock_flag | output | 1 | 1 while the machine is in LOCKED |
| win_done | output | 1 | One-cycle pulse after each completed window |

## Verification
A miscounted window shows at the ports as win_done arriving early or late. A wrong sum or threshold shows as a lock_flag verdict that disagrees with the bench's own arithmetic in that same pulse cycle. Both faults appear within one window of the error. Because the threshold is inclusive, the bench drives totals exactly on it and one below it, so an off-by-one compare flips lock_flag at the next pulse. A stale state or an unflushed sum after restart shows as a wrong verdict at the first window after the restart.

// File: rtl/lld_pkg.sv
package lld_pkg;

    typedef enum logic [0:0] {
        S_ACQUIRE = 1'b0,
        S_LOCKED  = 1'b1
    } lld_state_e;

endpackage

// File: rtl/lld_win_counter.sv
module lld_win_counter #(
    parameter int WIN_SHORT_LOG2 = 14,
    parameter int WIN_LONG_LOG2  = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic win_sel,
    input  logic ind_valid,
    output logic win_end
);
    localparam int CNT_W = WIN_LONG_LOG2;
    localparam logic [CNT_W-1:0] LONG_LAST  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] SHORT_LAST = LONG_LAST >> (WIN_LONG_LOG2 - WIN_SHORT_LOG2);

    logic [CNT_W-1:0] sym_cnt_q;
    logic [CNT_W-1:0] last_idx;

    assign last_idx = win_sel ? LONG_LAST : SHORT_LAST;
    assign win_end  = ind_valid && !restart && (sym_cnt_q >= last_idx);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sym_cnt_q <= '0;
        end else if (restart || win_end) begin
            sym_cnt_q <= '0;
        end else if (ind_valid) begin
            sym_cnt_q <= sym_cnt_q + 1'b1;
        end
    end

    // R9: restart empties the window count
    p_cnt_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (sym_cnt_q == '0));

    // R3: an unstrobed cycle leaves the count untouched
    p_idle_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ind_valid && !restart) |=> $stable(sym_cnt_q));

    // R2: windows are at least two symbols long, so ends never touch
    p_end_spaced_r2: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> !win_end);

endmodule

// File: rtl/lld_accum.sv
module lld_accum #(
    parameter int IND_W = 8,
    parameter int SUM_W = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             win_end,
    input  logic             ind_valid,
    input  logic [IND_W-1:0] ind_value,
    output logic [SUM_W-1:0] sum_full
);
    logic [SUM_W-1:0] acc_q;

    assign sum_full = acc_q + SUM_W'(ind_value);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (restart || win_end) begin
            acc_q <= '0;
        end else if (ind_valid) begin
            acc_q <= sum_full;
        end
    end

    // R10: adding a symbol never wraps the sum
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_valid && !restart && !win_end) |=> (acc_q >= $past(acc_q)));

    // R9: restart empties the sum
    p_acc_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (acc_q == '0));

endmodule

// File: rtl/lld_thresh.sv
module lld_thresh #(
    parameter int IND_W          = 8,
    parameter int WIN_SHORT_LOG2 = 14,
    parameter int WIN_LONG_LOG2  = 15,
    parameter int SUM_W          = IND_W + WIN_LONG_LOG2
) (
    input  logic             win_sel,
    input  logic             thr_sel,
    input  logic [IND_W-1:0] ideal_value,
    input  logic [SUM_W-1:0] sum_full,
    output logic             pass
);
    logic [SUM_W-1:0] ideal_ext;
    logic [SUM_W-1:0] ideal_sum;
    logic [SUM_W-1:0] half_sum;
    logic [SUM_W-1:0] quarter_sum;
    logic [SUM_W-1:0] thr;

    always_comb begin
        ideal_ext   = SUM_W'(ideal_value);
        ideal_sum   = win_sel ? (ideal_ext << WIN_LONG_LOG2) : (ideal_ext << WIN_SHORT_LOG2);
        half_sum    = ideal_sum >> 1;
        quarter_sum = ideal_sum >> 2;
        thr         = thr_sel ? (half_sum + quarter_sum) : half_sum;
        pass        = (sum_full >= thr);
    end

    // R5: the threshold never exceeds the ideal sum
    always_comb begin
        a_thr_bounded_r5: assert (thr <= ideal_sum);
    end

endmodule

// File: rtl/lld_lock_detect.sv
module lld_lock_detect #(
    parameter int IND_W          = 8,
    parameter int WIN_SHORT_LOG2 = 14,
    parameter int WIN_LONG_LOG2  = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             win_sel,
    input  logic             thr_sel,
    input  logic [IND_W-1:0] ideal_value,
    input  logic             ind_valid,
    input  logic [IND_W-1:0] ind_value,
    output logic             lock_flag,
    output logic             win_done
);
    import lld_pkg::*;

    localparam int SUM_W = IND_W + WIN_LONG_LOG2;

    logic             win_end;
    logic             pass;
    logic [SUM_W-1:0] sum_full;
    lld_state_e       state_q;
    lld_state_e       state_d;
    logic             done_q;

    lld_win_counter #(
        .WIN_SHORT_LOG2 (WIN_SHORT_LOG2),
        .WIN_LONG_LOG2  (WIN_LONG_LOG2)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .win_sel   (win_sel),
        .ind_valid (ind_valid),
        .win_end   (win_end)
    );

    lld_accum #(
        .IND_W (IND_W),
        .SUM_W (SUM_W)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .win_end   (win_end),
        .ind_valid (ind_valid),
        .ind_value (ind_value),
        .sum_full  (sum_full)
    );

    lld_thresh #(
        .IND_W          (IND_W),
        .WIN_SHORT_LOG2 (WIN_SHORT_LOG2),
        .WIN_LONG_LOG2  (WIN_LONG_LOG2),
        .SUM_W          (SUM_W)
    ) u_thr (
        .win_sel     (win_sel),
        .thr_sel     (thr_sel),
        .ideal_value (ideal_value),
        .sum_full    (sum_full),
        .pass        (pass)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (restart) begin
            state_d = S_ACQUIRE;                    // T_RESTART
        end else if (win_end) begin
            unique case (state_q)
                S_ACQUIRE: if (pass)  state_d = S_LOCKED;   // T_LOCK
                S_LOCKED:  if (!pass) state_d = S_ACQUIRE;  // T_DROP
                default:   state_d = S_ACQUIRE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_ACQUIRE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= win_end;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            S_LOCKED:  lock_flag = 1'b1;
            default:   lock_flag = 1'b0;
        endcase
        win_done = done_q;
    end

    // R8: the verdict moves only at a window end or a restart
    p_lock_at_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lock_flag) |-> ($past(win_end) || $past(restart)));

    // R9: restart drops the flag and suppresses the pulse
    p_restart_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!lock_flag && !win_done));

    // R6: a passing window always leaves the machine locked
    p_pass_locks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && pass) |=> lock_flag);

    // R7: a failing window always leaves the machine acquiring
    p_fail_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && !pass) |=> !lock_flag);

endmodule

// File: tb/lld_lock_detect_bench.sv
`timescale 1ns/1ps
module lld_lock_detect_bench;

    localparam int IND_W  = 8;
    localparam int S_LOG2 = 3;
    localparam int L_LOG2 = 4;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             restart;
    logic             win_sel;
    logic             thr_sel;
    logic [IND_W-1:0] ideal_value;
    logic             ind_valid;
    logic [IND_W-1:0] ind_value;
    logic             lock_flag;
    logic             win_done;

    int checks   = 0;
    int failures = 0;

    // Reference model state
    int  m_sum  = 0;
    int  m_cnt  = 0;
    bit  m_lock = 0;
    bit  m_done = 0;

    always #2.5 clk = ~clk;

    lld_lock_detect #(
        .IND_W          (IND_W),
        .WIN_SHORT_LOG2 (S_LOG2),
        .WIN_LONG_LOG2  (L_LOG2)
    ) u_lld_lock_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (restart),
        .win_sel     (win_sel),
        .thr_sel     (thr_sel),
        .ideal_value (ideal_value),
        .ind_valid   (ind_valid),
        .ind_value   (ind_value),
        .lock_flag   (lock_flag),
        .win_done    (win_done)
    );

    function automatic int win_len(bit sel);
        return sel ? (1 << L_LOG2) : (1 << S_LOG2);
    endfunction

    function automatic int threshold(int ideal, bit wsel, bit tsel);
        return (ideal * win_len(wsel) * (tsel ? 3 : 2)) / 4;
    endfunction

    task automatic check(string req, bit act, bit exp, string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // Called at a negedge: drive one cycle, advance model, compare at next negedge
    task automatic step(string req, bit rs, bit v, int val);
        restart   = rs;
        ind_valid = v;
        ind_value = IND_W'(val);
        if (rs) begin
            m_sum = 0; m_cnt = 0; m_lock = 0; m_done = 0;
        end else if (v) begin
            m_sum += val;
            m_cnt++;
            if (m_cnt == win_len(win_sel)) begin
                m_done = 1;
                m_lock = (m_sum >= threshold(ideal_value, win_sel, thr_sel));
                m_sum = 0; m_cnt = 0;
            end else begin
                m_done = 0;
            end
        end else begin
            m_done = 0;
        end
        @(negedge clk);
        check(req, lock_flag, m_lock, "lock_flag");
        check(req, win_done, m_done, "win_done");
    endtask

    task automatic feed_window(string req, int val);
        for (int i = 0; i < win_len(win_sel); i++) step(req, 0, 1, val);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; restart = 0; win_sel = 0; thr_sel = 0;
        ideal_value = 8'd100; ind_valid = 0; ind_value = 0;
        repeat (3) @(negedge clk);
        check("R1", lock_flag, 0, "lock_flag in reset");
        check("R1", win_done, 0, "win_done in reset");
        rst_n = 1;
        step("R1", 0, 0, 0);

        // R4/R6: half threshold 400 over 8 symbols; exactly equal passes
        feed_window("R6", 50);
        check("R6", lock_flag, 1, "equal to half threshold locks");
        // R7: one short of threshold drops
        for (int i = 0; i < 7; i++) step("R7", 0, 1, 50);
        step("R7", 0, 1, 49);
        check("R7", lock_flag, 0, "one below half threshold drops");
        // R4: failing window in ACQUIRE stays 0
        feed_window("R4", 40);
        check("R4", lock_flag, 0, "below half stays acquiring");

        // R5: three-quarter threshold 600
        step("R9", 1, 0, 0);
        thr_sel = 1;
        step("R5", 0, 0, 0);
        feed_window("R5", 74);
        check("R5", lock_flag, 0, "592 below 600 fails");
        feed_window("R5", 75);
        check("R5", lock_flag, 1, "600 meets 3/4 threshold");

        // R3: gaps ignored mid window; R2 pulse timing
        for (int i = 0; i < 7; i++) begin
            step("R3", 0, 1, 80);
            step("R3", 0, 0, 255);
            check("R2", win_done, 0, "no early pulse");
        end
        step("R2", 0, 1, 80);
        check("R2", win_done, 1, "pulse after 8th symbol");
        step("R2", 0, 0, 0);
        check("R2", win_done, 0, "pulse lasts one cycle");

        // R9: restart mid window with a concurrent strobe; long window
        for (int i = 0; i < 5; i++) step("R9", 0, 1, 200);
        step("R9", 1, 1, 255);
        check("R9", lock_flag, 0, "restart drops lock");
        win_sel = 1;
        step("R9", 0, 0, 0);
        feed_window("R2", 80);
        check("R2", win_done, 1, "long window pulse after 16 symbols");
        check("R6", lock_flag, 1, "1280 meets 1200");

        // R10: full-scale symbols with max ideal
        step("R10", 1, 0, 0);
        ideal_value = 8'd255;
        step("R10", 0, 0, 0);
        feed_window("R10", 255);
        check("R10", lock_flag, 1, "full scale passes without wrap");

        // Random phase: R8 cycle-by-cycle comparison
        ideal_value = 8'd160;
        for (int i = 0; i < 3000; i++) begin
            bit rs = ($urandom_range(0, 199) == 0);
            if (rs) begin
                win_sel = 1'($urandom_range(0, 1));
                thr_sel = 1'($urandom_range(0, 1));
            end
            step("R8", rs, ($urandom_range(0, 9) < 7), int'($urandom_range(60, 200)));
        end

        summary();
        $finish;
    end

endmodule